// File: doc/BRIEF.md
# Page-close prefetch release scheduler

This block sits between a hardware prefetcher and a DRAM bus scheduler. The prefetcher does not send reads on its own. It marks the cache lines it wants in a small table. Each tracked DRAM page has one entry in that table, and each entry has a tag and one bit for every line of the page. The marked lines are turned into reads only when they are cheap to serve. That happens in two cases: when the bus scheduler is about to close the page, or when a demand read arrives for the page while it is still open.

When the scheduler asks to close a page, the block raises `busy`. It then streams every marked line of that page, lowest line first, on a valid/ready output. After the last line it pulses `close_ok`, and the scheduler may then precharge the page. The burst happens only while the measured prefetch accuracy is above a programmable percentage. Accuracy is estimated from two saturating counters. One counts issued prefetches and the other counts prefetches reported useful.

Back-pressure rules for the close burst stream (`pf_valid`/`pf_ready`):
- Once `pf_valid` is high it stays high, with `pf_line` and `pf_tag` unchanged, until `pf_ready` is seen high at a clock edge.
- The downstream side may hold `pf_ready` low for any number of cycles.

Marks, demand notices, close requests and useful reports are plain single-cycle pulses and are always taken. The piggyback output `pb_valid` is a one-cycle notice with no back-pressure.

Top module: `pgmap_prefetch_sched`

## Requirements
- R1: A mark on (tag, line) sets that line's bit in the page entry with that tag, allocating an entry when no valid entry has the tag. Marking a line that is already set leaves the entry unchanged, so the line is issued only once.
- R2: When a mark needs a new entry and all 8 entries are valid, the entry that was least recently marked is reused. Its old tag and all of its old bits are dropped. When some entries are free, the lowest-numbered free entry is used.
- R3: A close request accepted while accuracy is good issues every marked line of that page on the stream, one per accepted transfer, in strictly ascending line order. `pf_tag` carries the page tag. `pf_line` and `pf_tag` stay stable while `pf_ready` is low.
- R4: A close request accepted while accuracy is not good, or for a page with no entry, issues no lines.
- R5: A close request is accepted only while `busy` is low. `busy` rises the cycle after acceptance. `close_ok` is high for exactly one cycle, the cycle after the last accepted transfer (or the cycle after acceptance when nothing is issued). `busy` falls the cycle after `close_ok`. The page's entry is removed when the close is accepted.
- R6: A demand notice taken while `busy` and `close_req` are both low, for a page whose entry has marked lines, produces a `pb_valid` pulse on the next cycle. That pulse carries the tag and the lowest-numbered marked line, and that bit is cleared. At most one line is issued per demand notice. No pulse is produced in any other case.
- R7: `acc_ok` is high exactly when useful*100 > threshold*issued. `issued` counts stream transfers and piggyback pulses. `useful` counts `pf_useful` pulses. Both counters are 10 bits and saturate at 1023. After reset both are zero, so `acc_ok` is low.
- R8: When an increment would bring `issued` to 1023, both counters are stored halved (rounded down) instead.
- R9: The threshold percentage resets to 38. It takes `thr_wdata` on any cycle with `thr_we` high, and it changes the `acc_ok` decision from the next cycle.
- R10: A mark is ignored if its tag equals `close_tag` in a cycle where the close is accepted, or equals the tag of the close burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Load accuracy threshold |
| thr_wdata | input | 7 | New threshold in percent |
| mark_valid | input | 1 | Prefetcher mark pulse |
| mark_tag | input | 16 | Page tag of the mark |
| mark_line | input | 5 | Line within the page to mark |
| close_req | input | 1 | Scheduler wants to close a page |
| close_tag | input | 16 | Tag of the page to close |
| busy | output | 1 | Close sequence in progress |
| close_ok | output | 1 | Page may close now (one cycle) |
| pf_valid | output | 1 | Close burst line valid |
| pf_ready | input | 1 | Close burst line accepted |
| pf_tag | output | 16 | Page tag of the burst line |
| pf_line | output | 5 | Line number of the burst line |
| demand_valid | input | 1 | Demand read to an open page |
| demand_tag | input | 16 | Tag of the demand page |
| pb_valid | output | 1 | Piggyback prefetch notice |
| pb_tag | output | 16 | Page tag of the piggyback line |
| pb_line | output | 5 | Line number of the piggyback line |
| pf_useful | input | 1 | A prefetched line was used |
| acc_ok | output | 1 | Accuracy above threshold |

## Verification
The close burst is tried with sparse marks that include the end lines 0 and 31, with back-pressure held in random patterns. This separates correct ordering from a design that skips or repeats a line while stalled. Piggyback is tried with repeated marks of the same line and with pages refreshed before eviction. These cases tell "lowest bit, one per notice" apart from bulk release, and least-recently-marked from oldest-allocated replacement. A long piggyback run past 1023 issues shows the halving step, because afterwards the two counter pairs give opposite accuracy verdicts. A random mix of all inputs, compared each cycle with a behavioural model, covers marks that collide with closes and with evictions.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int unsigned PCT_W          = 7;
  localparam logic [6:0]  DEF_THRESH_PCT = 7'd38;
  localparam int unsigned PCT_SCALE      = 100;
endpackage

// File: rtl/pgmap_first_set.sv
// Lowest-index set bit finder.
module pgmap_first_set #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]         vec,
  output logic                 found,
  output logic [$clog2(W)-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = ($clog2(W))'(i);
    end
  end
endmodule

// File: rtl/pgmap_accuracy.sv
// Issued/useful counters and the threshold comparison (R7, R8).
module pgmap_accuracy #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_issued,
  input  logic             inc_useful,
  input  logic [PCT_W-1:0] thresh,
  output logic             acc_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int unsigned      PW      = CNT_W + PCT_W + 1;

  logic [CNT_W-1:0] issued_q, useful_q, i_sum, u_sum;
  logic [PW-1:0]    lhs, rhs;

  always_comb begin
    i_sum = (inc_issued && issued_q != CNT_MAX) ? issued_q + 1'b1 : issued_q;
    u_sum = (inc_useful && useful_q != CNT_MAX) ? useful_q + 1'b1 : useful_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issued_q <= '0;
      useful_q <= '0;
    end else if (i_sum == CNT_MAX) begin
      issued_q <= i_sum >> 1;
      useful_q <= u_sum >> 1;
    end else begin
      issued_q <= i_sum;
      useful_q <= u_sum;
    end
  end

  assign lhs    = PW'(useful_q) * PW'(pgmap_pkg::PCT_SCALE);
  assign rhs    = PW'(thresh) * PW'(issued_q);
  assign acc_ok = lhs > rhs;

  // R8: the stored issued count never sits at the saturation value
  a_r8_halved_before_max: assert property (@(posedge clk) disable iff (!rst_n)
    issued_q != CNT_MAX);
  // R7: issued moves by at most one step unless a halving occurred
  a_r7_issued_step: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_issued |=> issued_q <= $past(issued_q));
endmodule

// File: rtl/pgmap_prefetch_sched.sv
module pgmap_prefetch_sched #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned LINES = 32,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned CNT_W = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             thr_we,
  input  logic [pgmap_pkg::PCT_W-1:0]      thr_wdata,
  input  logic                             mark_valid,
  input  logic [TAG_W-1:0]                 mark_tag,
  input  logic [$clog2(LINES)-1:0]         mark_line,
  input  logic                             close_req,
  input  logic [TAG_W-1:0]                 close_tag,
  output logic                             busy,
  output logic                             close_ok,
  output logic                             pf_valid,
  input  logic                             pf_ready,
  output logic [TAG_W-1:0]                 pf_tag,
  output logic [$clog2(LINES)-1:0]         pf_line,
  input  logic                             demand_valid,
  input  logic [TAG_W-1:0]                 demand_tag,
  output logic                             pb_valid,
  output logic [TAG_W-1:0]                 pb_tag,
  output logic [$clog2(LINES)-1:0]         pb_line,
  input  logic                             pf_useful,
  output logic                             acc_ok
);
  localparam int unsigned LW = $clog2(LINES);
  localparam int unsigned EW = $clog2(N_ENT);

  // Line-mark table
  logic [N_ENT-1:0] valid_q, valid_n;
  logic [TAG_W-1:0] tag_q  [N_ENT];
  logic [TAG_W-1:0] tag_n  [N_ENT];
  logic [LINES-1:0] bits_q [N_ENT];
  logic [LINES-1:0] bits_n [N_ENT];
  logic [EW-1:0]    rank_q [N_ENT];   // 0 = most recently marked
  logic [EW-1:0]    rank_n [N_ENT];

  logic [pgmap_pkg::PCT_W-1:0] thr_q;

  // Close burst state
  logic             busy_q;
  logic [LINES-1:0] bv_q;
  logic [TAG_W-1:0] btag_q;

  logic             pb_valid_q;
  logic [TAG_W-1:0] pb_tag_q;
  logic [LW-1:0]    pb_line_q;

  logic [N_ENT-1:0] mark_hit, close_hit, dem_hit;
  logic             mhit_found, free_found, chit_found, dhit_found, dline_found, b_found;
  logic [EW-1:0]    mhit_idx, free_idx, cidx, didx, victim_idx, midx;
  logic [LW-1:0]    dline, b_line;

  logic close_acc, mark_ign, mark_go, dem_go, pb_go, pf_fire;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign mark_hit[g]  = valid_q[g] && (tag_q[g] == mark_tag);
    assign close_hit[g] = valid_q[g] && (tag_q[g] == close_tag);
    assign dem_hit[g]   = valid_q[g] && (tag_q[g] == demand_tag);
  end

  pgmap_first_set #(.W(N_ENT)) u_mhit  (.vec(mark_hit),  .found(mhit_found), .idx(mhit_idx));
  pgmap_first_set #(.W(N_ENT)) u_free  (.vec(~valid_q),  .found(free_found), .idx(free_idx));
  pgmap_first_set #(.W(N_ENT)) u_chit  (.vec(close_hit), .found(chit_found), .idx(cidx));
  pgmap_first_set #(.W(N_ENT)) u_dhit  (.vec(dem_hit),   .found(dhit_found), .idx(didx));
  pgmap_first_set #(.W(LINES)) u_dline (.vec(bits_q[didx]), .found(dline_found), .idx(dline));
  pgmap_first_set #(.W(LINES)) u_bline (.vec(bv_q),      .found(b_found),    .idx(b_line));

  always_comb begin
    victim_idx = '0;
    for (int j = 0; j < N_ENT; j++) begin
      if (rank_q[j] == EW'(N_ENT - 1)) victim_idx = EW'(j);
    end
  end

  assign close_acc = close_req && !busy_q;
  assign mark_ign  = (close_acc && mark_tag == close_tag) || (busy_q && mark_tag == btag_q);
  assign mark_go   = mark_valid && !mark_ign;
  assign midx      = mhit_found ? mhit_idx : (free_found ? free_idx : victim_idx);
  assign dem_go    = demand_valid && !busy_q && !close_req;
  assign pb_go     = dem_go && dhit_found && dline_found;

  assign pf_valid = busy_q && b_found;
  assign close_ok = busy_q && !b_found;
  assign pf_fire  = pf_valid && pf_ready;
  assign pf_line  = b_line;
  assign pf_tag   = btag_q;
  assign busy     = busy_q;
  assign pb_valid = pb_valid_q;
  assign pb_tag   = pb_tag_q;
  assign pb_line  = pb_line_q;

  // Table update: close clear, piggyback clear, then mark (allocation may
  // reuse the entry just cleared, R2/R5).
  always_comb begin
    valid_n = valid_q;
    for (int i = 0; i < N_ENT; i++) begin
      tag_n[i]  = tag_q[i];
      bits_n[i] = bits_q[i];
      rank_n[i] = rank_q[i];
    end
    if (close_acc && chit_found) begin
      valid_n[cidx] = 1'b0;
      bits_n[cidx]  = '0;
    end
    if (pb_go) bits_n[didx][dline] = 1'b0;
    if (mark_go) begin
      if (!mhit_found) begin
        valid_n[midx] = 1'b1;
        tag_n[midx]   = mark_tag;
        bits_n[midx]  = '0;
      end
      bits_n[midx][mark_line] = 1'b1;
      for (int j = 0; j < N_ENT; j++) begin
        if (rank_q[j] < rank_q[midx]) rank_n[j] = rank_q[j] + EW'(1);
      end
      rank_n[midx] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        tag_q[i]  <= '0;
        bits_q[i] <= '0;
        rank_q[i] <= EW'(i);
      end
    end else begin
      valid_q <= valid_n;
      for (int i = 0; i < N_ENT; i++) begin
        tag_q[i]  <= tag_n[i];
        bits_q[i] <= bits_n[i];
        rank_q[i] <= rank_n[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      bv_q       <= '0;
      btag_q     <= '0;
      pb_valid_q <= 1'b0;
      pb_tag_q   <= '0;
      pb_line_q  <= '0;
      thr_q      <= pgmap_pkg::DEF_THRESH_PCT;
    end else begin
      if (close_acc) begin
        busy_q <= 1'b1;
        btag_q <= close_tag;
        bv_q   <= (chit_found && acc_ok) ? bits_q[cidx] : '0;
      end else if (busy_q) begin
        if (close_ok)     busy_q       <= 1'b0;
        else if (pf_fire) bv_q[b_line] <= 1'b0;
      end
      pb_valid_q <= pb_go;
      if (pb_go) begin
        pb_tag_q  <= tag_q[didx];
        pb_line_q <= dline;
      end
      if (thr_we) thr_q <= thr_wdata;
    end
  end

  pgmap_accuracy #(.CNT_W(CNT_W), .PCT_W(pgmap_pkg::PCT_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_issued (pf_fire || pb_go),
    .inc_useful (pf_useful),
    .thresh     (thr_q),
    .acc_ok     (acc_ok)
  );

  // R3: a stalled line holds its value
  a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line) && $stable(pf_tag)));
  // R3: lines leave in ascending order within a burst
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready) |=> (!pf_valid || pf_line > $past(pf_line)));
  // R5: close_ok is a single pulse that ends the busy window
  a_r5_ok_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    close_ok |=> (!close_ok && !busy));
  // R6: piggyback only follows a demand taken outside a close
  a_r6_pb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    pb_valid |-> $past(demand_valid && !busy && !close_req));
endmodule

// File: tb/pgmap_prefetch_sched_tb.sv
module pgmap_prefetch_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        thr_we;
  logic [6:0]  thr_wdata;
  logic        mark_valid;
  logic [15:0] mark_tag;
  logic [4:0]  mark_line;
  logic        close_req;
  logic [15:0] close_tag;
  logic        busy, close_ok, pf_valid, pf_ready;
  logic [15:0] pf_tag;
  logic [4:0]  pf_line;
  logic        demand_valid;
  logic [15:0] demand_tag;
  logic        pb_valid;
  logic [15:0] pb_tag;
  logic [4:0]  pb_line;
  logic        pf_useful, acc_ok;

  pgmap_prefetch_sched u_dut (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .mark_valid(mark_valid), .mark_tag(mark_tag), .mark_line(mark_line),
    .close_req(close_req), .close_tag(close_tag), .busy(busy), .close_ok(close_ok),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_tag(pf_tag), .pf_line(pf_line),
    .demand_valid(demand_valid), .demand_tag(demand_tag), .pb_valid(pb_valid),
    .pb_tag(pb_tag), .pb_line(pb_line), .pf_useful(pf_useful), .acc_ok(acc_ok)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        m_val [NE];
  int        m_tag [NE];
  bit [31:0] m_bits [NE];
  longint    m_stamp [NE];
  longint    stamp_ctr;
  bit        m_busy;
  bit [31:0] m_bv;
  int        m_btag;
  bit        m_pbv;
  int        m_pbtag, m_pbline;
  int        iss, use_c, thr;

  function automatic int m_find(int t);
    for (int i = 0; i < NE; i++) if (m_val[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int lowbit(bit [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit m_acc();
    return (use_c * 100) > (thr * iss);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NE; i++) begin
      m_val[i] = 0; m_tag[i] = 0; m_bits[i] = 0; m_stamp[i] = 0;
    end
    stamp_ctr = 0; m_busy = 0; m_bv = 0; m_btag = 0; m_pbv = 0;
    m_pbtag = 0; m_pbline = 0; iss = 0; use_c = 0; thr = 38;
  endtask

  task automatic model_step();
    bit cacc, acc, dgo, ign, mgo, fire, pbgo;
    int ci, di, mi, fi, vi, t;
    longint best;
    cacc = close_req && !m_busy;
    ci   = m_find(int'(close_tag));
    acc  = m_acc();
    dgo  = demand_valid && !m_busy && !close_req;
    di   = m_find(int'(demand_tag));
    ign  = (cacc && mark_tag == close_tag) || (m_busy && int'(mark_tag) == m_btag);
    mgo  = mark_valid && !ign;
    mi   = m_find(int'(mark_tag));
    fi   = -1;
    for (int i = NE - 1; i >= 0; i--) if (!m_val[i]) fi = i;
    vi = 0; best = -1;
    for (int i = 0; i < NE; i++)
      if (m_val[i] && (best < 0 || m_stamp[i] < best)) begin best = m_stamp[i]; vi = i; end
    fire = m_busy && (m_bv != 0) && pf_ready;
    pbgo = 0;
    m_pbv = 0;
    if (dgo && di >= 0 && m_bits[di] != 0) begin
      pbgo = 1; m_pbv = 1; m_pbtag = m_tag[di]; m_pbline = lowbit(m_bits[di]);
      m_bits[di][m_pbline] = 1'b0;
    end
    if (cacc) begin
      m_busy = 1; m_btag = int'(close_tag);
      m_bv = (ci >= 0 && acc) ? m_bits[ci] : 32'd0;
      if (ci >= 0) begin m_val[ci] = 0; m_bits[ci] = 0; end
    end else if (m_busy) begin
      if (m_bv == 0) m_busy = 0;
      else if (pf_ready) m_bv[lowbit(m_bv)] = 1'b0;
    end
    if (mgo) begin
      t = (mi >= 0) ? mi : ((fi >= 0) ? fi : vi);
      if (mi < 0) begin m_val[t] = 1; m_tag[t] = int'(mark_tag); m_bits[t] = 0; end
      m_bits[t][mark_line] = 1'b1;
      stamp_ctr++;
      m_stamp[t] = stamp_ctr;
    end
    if (fire || pbgo) iss = (iss < 1023) ? iss + 1 : 1023;
    if (pf_useful) use_c = (use_c < 1023) ? use_c + 1 : 1023;
    if (iss == 1023) begin iss = iss / 2; use_c = use_c / 2; end
    if (thr_we) thr = int'(thr_wdata);
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit epf;
      epf = m_busy && (m_bv != 0);
      chk(busy == m_busy, "R5", "busy", busy, m_busy);
      chk(close_ok == (m_busy && m_bv == 0), "R5", "close_ok", close_ok, m_busy && m_bv == 0);
      chk(pf_valid == epf, "R3", "pf_valid", pf_valid, epf);
      if (epf) begin
        chk(int'(pf_line) == lowbit(m_bv), "R3", "pf_line", pf_line, lowbit(m_bv));
        chk(int'(pf_tag) == m_btag, "R3", "pf_tag", pf_tag, m_btag);
      end
      chk(pb_valid == m_pbv, "R6", "pb_valid", pb_valid, m_pbv);
      if (m_pbv) begin
        chk(int'(pb_line) == m_pbline, "R6", "pb_line", pb_line, m_pbline);
        chk(int'(pb_tag) == m_pbtag, "R6", "pb_tag", pb_tag, m_pbtag);
      end
      chk(acc_ok == m_acc(), "R7", "acc_ok", acc_ok, m_acc());
    end
  end

  // ---------------- stimulus helpers (entered at a falling edge) --------
  task automatic do_mark(input int t, input int l);
    mark_valid = 1; mark_tag = 16'(t); mark_line = 5'(l);
    @(negedge clk);
    mark_valid = 0;
  endtask

  task automatic demand_chk(input int t, input bit ev, input int el, input string req);
    demand_valid = 1; demand_tag = 16'(t);
    @(negedge clk);
    demand_valid = 0;
    chk(pb_valid == ev, req, "piggyback valid", pb_valid, ev);
    if (ev) chk(int'(pb_line) == el, req, "piggyback line", pb_line, el);
  endtask

  task automatic close_collect(input int t, input int same_mark, output int q[$]);
    int guard;
    q = {};
    close_req = 1; close_tag = 16'(t);
    if (same_mark >= 0) begin
      mark_valid = 1; mark_tag = 16'(t); mark_line = 5'(same_mark);
    end
    @(negedge clk);
    close_req = 0; mark_valid = 0;
    guard = 0;
    while (!close_ok && guard < 200) begin
      pf_ready = ($urandom_range(0, 2) != 0);
      if (pf_valid && pf_ready) q.push_back(int'(pf_line));
      @(negedge clk);
      guard++;
    end
    chk(close_ok == 1'b1, "R5", "close_ok reached", close_ok, 1);
    pf_ready = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      chk(0, "R5", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int q[$];
    rst_n = 0; thr_we = 0; thr_wdata = 0; mark_valid = 0; mark_tag = 0; mark_line = 0;
    close_req = 0; close_tag = 0; pf_ready = 1; demand_valid = 0; demand_tag = 0;
    pf_useful = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    chk(busy == 0 && pf_valid == 0 && close_ok == 0, "R5", "reset idle", busy, 0);
    chk(pb_valid == 0, "R6", "reset pb", pb_valid, 0);
    chk(acc_ok == 0, "R7", "reset accuracy", acc_ok, 0);

    // R4: close with accuracy low issues nothing; R5: entry removed
    do_mark(100, 3); do_mark(100, 7); do_mark(100, 31);
    close_collect(100, -1, q);
    chk(q.size() == 0, "R4", "lines at low accuracy", q.size(), 0);
    demand_chk(100, 0, 0, "R5");

    // R1 duplicate mark, R6 lowest line first, one per notice
    do_mark(200, 7); do_mark(200, 3); do_mark(200, 3);
    demand_chk(200, 1, 3, "R6");
    demand_chk(200, 1, 7, "R1");
    demand_chk(200, 0, 0, "R1");

    // R7: useful reports raise accuracy (use 5, issued 2)
    pf_useful = 1; repeat (5) @(negedge clk); pf_useful = 0;
    chk(acc_ok == 1, "R7", "accuracy after useful", acc_ok, 1);

    // R3: burst in ascending order with back-pressure
    do_mark(300, 31); do_mark(300, 0); do_mark(300, 17); do_mark(300, 5);
    close_collect(300, -1, q);
    chk(q.size() == 4, "R3", "burst length", q.size(), 4);
    if (q.size() == 4) begin
      chk(q[0] == 0 && q[1] == 5 && q[2] == 17 && q[3] == 31, "R3", "burst order",
          q[1], 5);
    end

    // R10: mark on page closing in the same cycle is ignored
    do_mark(400, 2);
    close_collect(400, 9, q);
    chk(q.size() == 1, "R10", "burst with same-cycle mark", q.size(), 1);
    demand_chk(400, 0, 0, "R10");

    // R2: free entries first, then least recently marked is replaced
    for (int i = 0; i < 8; i++) do_mark(500 + i, i);
    do_mark(500, 4);            // refresh 500, 501 now least recent
    do_mark(508, 8);
    demand_chk(501, 0, 0, "R2");
    demand_chk(500, 1, 0, "R2");
    demand_chk(502, 1, 2, "R2");

    // R9: raising threshold blocks the burst; lowering releases it
    do_mark(503, 20);
    thr_we = 1; thr_wdata = 7'd99; @(negedge clk); thr_we = 0;
    chk(acc_ok == 0, "R9", "accuracy at 99 percent", acc_ok, 0);
    close_collect(503, -1, q);
    chk(q.size() == 0, "R9", "burst at high threshold", q.size(), 0);
    thr_we = 1; thr_wdata = 7'd0; @(negedge clk); thr_we = 0;
    chk(acc_ok == 1, "R9", "accuracy at 0 percent", acc_ok, 1);
    close_collect(504, -1, q);
    chk(q.size() == 1 && q[0] == 4, "R9", "burst at low threshold", q.size(), 1);

    // R8: halving at saturation
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    pf_useful = 1; repeat (400) @(negedge clk); pf_useful = 0;
    mark_valid = 1; mark_tag = 16'd600; mark_line = 5'd0;
    demand_valid = 1; demand_tag = 16'd600;
    repeat (1001) @(negedge clk);
    chk(acc_ok == 1, "R7", "accuracy at 1000 issues", acc_ok, 1);
    repeat (123) @(negedge clk);
    mark_valid = 0; demand_valid = 0;
    chk(acc_ok == 0, "R8", "accuracy after halving", acc_ok, 0);
    @(negedge clk);

    // Random mix
    for (int c = 0; c < 4000; c++) begin
      mark_valid   = ($urandom_range(0, 1) == 1);
      mark_tag     = 16'($urandom_range(1, 12));
      mark_line    = 5'($urandom_range(0, 31));
      demand_valid = ($urandom_range(0, 3) == 0);
      demand_tag   = 16'($urandom_range(1, 12));
      close_req    = ($urandom_range(0, 15) == 0);
      close_tag    = 16'($urandom_range(1, 12));
      pf_ready     = ($urandom_range(0, 3) != 0);
      pf_useful    = ($urandom_range(0, 7) == 0);
      thr_we       = ($urandom_range(0, 199) == 0);
      thr_wdata    = 7'($urandom_range(10, 60));
      @(negedge clk);
    end
    mark_valid = 0; demand_valid = 0; close_req = 0; pf_useful = 0; thr_we = 0;
    pf_ready = 1;
    repeat (40) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule